// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block sits between the fetch unit and an instruction translation buffer. Each cycle a fetch request may be presented. The block works out the physical address for that fetch, or the fault it must raise, and answers one clock later with a physical address, an uncached flag and a fault code. The entry store is outside the block. The block drives the virtual page number to that store on `lookup_vpn`. The store returns hit, frame number and a per-mode read-enable mask in the same cycle.

Five paths are resolved in a fixed priority order:

1. A privileged fetch address (bit 0 set) bypasses translation.
2. A non-canonical address is refused with an access violation.
3. A kernel-only superpage window maps virtual to physical directly.
4. A missing entry raises a miss.
5. An entry that does not grant the current mode raises an access violation.

Whenever a fault is raised, two fault registers are loaded. One holds the faulting address. The other holds a formatted address, built for software refill handlers from the page-table base and the page number.

Pages are 8 KB. The implemented virtual address tops out at bit 42, and the implemented physical width is 44 bits.

Top module: `itx_fetch_xlate`

## Requirements
- R1: When `req_va[0]` is 1, the response is fault code NONE (0). `rsp_pa` equals `req_va[PA_W-1:0]` with bits 1:0 cleared, and `rsp_uncached` is 0. This holds whatever the mode, superpage enable, range or lookup inputs are.
- R2: Otherwise, if `req_va[63:43]` is not all equal to `req_va[42]`, the response is fault code ACV (1).
- R3: Otherwise, the superpage window applies when `sp_en[1]` is 1 and `req_va[42:41]` is 2'b10. If `cur_mode` is kernel (2'b00) in that case, `rsp_pa` is `req_va[39:0]` zero-extended, with no fault, and the lookup inputs are ignored.
- R4: In the superpage window with `cur_mode` other than 2'b00, the response is fault code ACV (1).
- R5: `lookup_vpn` always equals `req_va[42:13]`. Outside the bypass, range and superpage paths, `tlb_hit` = 0 gives fault code MISS (2).
- R6: On a hit whose mask grants the mode, `rsp_pa` = {`tlb_pfn`, `req_va[12:2]`, 2'b00} with no fault.
- R7: On a hit with `tlb_rd_en[cur_mode]` = 0, the response is fault code ACV (1).
- R8: On any fault, `fault_tag` captures `req_va` and `fault_form` captures `ptbr` OR (`req_va[42:13]` << 3). Both hold their value on every other cycle, and both are 0 after reset.
- R9: On a fault, `rsp_pa` is 0 and `rsp_uncached` is 0. On a non-bypass success, `rsp_uncached` equals `rsp_pa[43]`.
- R10: `rsp_valid` is `req_valid` delayed by one clock, and the response fields belong to that request. Reset (active-low, synchronous) clears `rsp_valid` and all response fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Fetch request present |
| req_va | input | 64 | Fetch virtual address |
| cur_mode | input | 2 | Current mode, 0 = kernel |
| sp_en | input | 2 | Superpage enable; bit 1 opens the fetch window |
| ptbr | input | 64 | Page-table base for the formatted fault address |
| lookup_vpn | output | 30 | Page number sent to the entry store |
| tlb_hit | input | 1 | Entry store found a match |
| tlb_pfn | input | 31 | Page frame number of the match |
| tlb_rd_en | input | 4 | Read-enable mask, bit n grants mode n |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 44 | Physical address |
| rsp_uncached | output | 1 | Physical address lies in uncached space |
| rsp_fault | output | 2 | 0 none, 1 access violation, 2 miss |
| fault_tag | output | 64 | Address of the last faulting fetch |
| fault_form | output | 64 | Formatted address of the last faulting fetch |

## Verification
The assertions assume that the lookup inputs are stable, combinational answers for the `lookup_vpn` shown in the same cycle. They also assume that `req_valid` and the request fields are known, not X, during and after reset. The bench drives every input from a single task at the falling edge and holds `req_valid` low through reset. Its random addresses are drawn per class (bypass, non-canonical, superpage, canonical), so that each priority path is reached while the other fields stay random.

// File: rtl/itx_pkg.sv
// Package: shared types and encodings for the fetch address translator.
// Assumes mode 0 is the most privileged (kernel) mode.
package itx_pkg;
    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_ACV  = 2'd1,
        FLT_MISS = 2'd2
    } fault_e;

    localparam logic [1:0] MODE_KERNEL = 2'd0;
endpackage

// File: rtl/itx_classify.sv
// Module: itx_classify
// Decides, purely combinationally, the physical address, uncached flag and
// fault code for one fetch address. Assumes the lookup inputs already
// answer for this address's page number.
module itx_classify
    import itx_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int VA_HI    = 42,
    parameter int PA_W     = 44,
    parameter int PG_BITS  = 13,
    parameter int SP_PA_HI = 39,
    parameter int MODE_W   = 2
) (
    input  logic [VA_W-1:0]          va,
    input  logic [MODE_W-1:0]        mode,
    input  logic [1:0]               sp_en,
    input  logic                     hit,
    input  logic [PA_W-PG_BITS-1:0]  pfn,
    input  logic [(1<<MODE_W)-1:0]   rd_en,
    output fault_e                   fault,
    output logic [PA_W-1:0]          pa,
    output logic                     uncached
);
    localparam int UP_W = VA_W - VA_HI;

    logic [UP_W-1:0] upper;
    logic            canonical;
    logic            in_sp;
    logic [PA_W-1:0] sp_pa;
    logic [PA_W-1:0] pal_pa;
    logic [PA_W-1:0] hit_pa;

    assign upper     = va[VA_W-1:VA_HI];
    assign canonical = (&upper) | ~(|upper);
    assign in_sp     = sp_en[1] && (va[VA_HI:VA_HI-1] == 2'b10);
    assign pal_pa    = {va[PA_W-1:2], 2'b00};
    assign hit_pa    = {pfn, va[PG_BITS-1:2], 2'b00};

    // Superpage address: the window's bits pass through, anything above is zero.
    generate
        if (PA_W > SP_PA_HI + 1) begin : g_sp_pad
            assign sp_pa = {{(PA_W-SP_PA_HI-1){1'b0}}, va[SP_PA_HI:0]};
        end else begin : g_sp_trunc
            assign sp_pa = va[PA_W-1:0];
        end
    endgenerate

    // Priority decision: bypass, range, superpage, miss, permission.
    always_comb begin
        fault    = FLT_NONE;
        pa       = '0;
        uncached = 1'b0;
        if (va[0]) begin
            pa = pal_pa;
        end else if (!canonical) begin
            fault = FLT_ACV;
        end else if (in_sp) begin
            if (mode != MODE_KERNEL) begin
                fault = FLT_ACV;
            end else begin
                pa       = sp_pa;
                uncached = sp_pa[PA_W-1];
            end
        end else if (!hit) begin
            fault = FLT_MISS;
        end else if (!rd_en[mode]) begin
            fault = FLT_ACV;
        end else begin
            pa       = hit_pa;
            uncached = hit_pa[PA_W-1];
        end
    end
endmodule

// File: rtl/itx_fault_regs.sv
// Module: itx_fault_regs
// Holds the faulting address and its formatted form for a refill handler.
// Assumes capture is asserted only for a request that faults.
module itx_fault_regs #(
    parameter int VA_W    = 64,
    parameter int VA_HI   = 42,
    parameter int PG_BITS = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [VA_W-1:0] va,
    input  logic [VA_W-1:0] ptbr,
    output logic [VA_W-1:0] tag_q,
    output logic [VA_W-1:0] form_q
);
    localparam int VPN_W = VA_HI + 1 - PG_BITS;
    localparam int PAD_W = VA_W - VPN_W - 3;

    logic [VA_W-1:0] vpn_x8;
    assign vpn_x8 = {{PAD_W{1'b0}}, va[VA_HI:PG_BITS], 3'b000};

    // Load both registers on a fault, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            form_q <= '0;
        end else if (capture) begin
            tag_q  <= va;
            form_q <= ptbr | vpn_x8;
        end
    end

    // Fault registers may only move in a cycle that captured.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture) |-> ($stable(tag_q) && $stable(form_q)));
endmodule

// File: rtl/itx_fetch_xlate.sv
// Module: itx_fetch_xlate (top)
// Registers one translation response per fetch request, one clock after it,
// and updates the fault registers on any fault. Assumes the entry store
// answers combinationally for lookup_vpn.
module itx_fetch_xlate
    import itx_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int VA_HI    = 42,
    parameter int PA_W     = 44,
    parameter int PG_BITS  = 13,
    parameter int SP_PA_HI = 39,
    parameter int MODE_W   = 2,
    localparam int VPN_W   = VA_HI + 1 - PG_BITS,
    localparam int PFN_W   = PA_W - PG_BITS,
    localparam int NMODES  = 1 << MODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_va,
    input  logic [MODE_W-1:0]  cur_mode,
    input  logic [1:0]         sp_en,
    input  logic [VA_W-1:0]    ptbr,
    output logic [VPN_W-1:0]   lookup_vpn,
    input  logic               tlb_hit,
    input  logic [PFN_W-1:0]   tlb_pfn,
    input  logic [NMODES-1:0]  tlb_rd_en,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_pa,
    output logic               rsp_uncached,
    output logic [1:0]         rsp_fault,
    output logic [VA_W-1:0]    fault_tag,
    output logic [VA_W-1:0]    fault_form
);
    fault_e          c_fault;
    logic [PA_W-1:0] c_pa;
    logic            c_unc;
    logic            capture;

    assign lookup_vpn = req_va[VA_HI:PG_BITS];
    assign capture    = req_valid && (c_fault != FLT_NONE);

    itx_classify #(
        .VA_W(VA_W), .VA_HI(VA_HI), .PA_W(PA_W), .PG_BITS(PG_BITS),
        .SP_PA_HI(SP_PA_HI), .MODE_W(MODE_W)
    ) u_classify (
        .va(req_va), .mode(cur_mode), .sp_en(sp_en), .hit(tlb_hit),
        .pfn(tlb_pfn), .rd_en(tlb_rd_en),
        .fault(c_fault), .pa(c_pa), .uncached(c_unc)
    );

    itx_fault_regs #(
        .VA_W(VA_W), .VA_HI(VA_HI), .PG_BITS(PG_BITS)
    ) u_fregs (
        .clk(clk), .rst_n(rst_n), .capture(capture), .va(req_va),
        .ptbr(ptbr), .tag_q(fault_tag), .form_q(fault_form)
    );

    // Response register: one clock after the request it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_pa       <= '0;
            rsp_uncached <= 1'b0;
            rsp_fault    <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa       <= c_pa;
                rsp_uncached <= c_unc;
                rsp_fault    <= c_fault;
            end
        end
    end

    // A privileged fetch never faults and is never flagged uncached.
    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_va[0]) |->
            (rsp_fault == FLT_NONE && !rsp_uncached));

    // A non-canonical, non-privileged fetch is an access violation.
    assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_va[0] &&
              !((&req_va[VA_W-1:VA_HI]) || !(|req_va[VA_W-1:VA_HI])))
        |-> rsp_fault == FLT_ACV);

    // Superpage window entered outside kernel mode faults.
    assert_sp_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_va[0] && (&req_va[VA_W-1:VA_HI]) && sp_en[1] &&
              req_va[VA_HI-1] == 1'b0 && cur_mode != MODE_KERNEL)
        |-> rsp_fault == FLT_ACV);

    // The fault tag reflects the request whose response is a fault.
    assert_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> fault_tag == $past(req_va));

    // A faulting response carries no address and no uncached flag.
    assert_fault_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_pa == '0 && !rsp_uncached));

    // The response valid follows the request valid by one clock.
    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));
endmodule

// File: tb/test_itx_fetch_xlate.sv
`timescale 1ns/100ps
module test_itx_fetch_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [1:0]  cur_mode = '0;
    logic [1:0]  sp_en = '0;
    logic [63:0] ptbr = '0;
    logic [29:0] lookup_vpn;
    logic        tlb_hit = 1'b0;
    logic [30:0] tlb_pfn = '0;
    logic [3:0]  tlb_rd_en = '0;
    logic        rsp_valid;
    logic [43:0] rsp_pa;
    logic        rsp_uncached;
    logic [1:0]  rsp_fault;
    logic [63:0] fault_tag;
    logic [63:0] fault_form;

    int checks = 0;
    int fails  = 0;
    logic [63:0] exp_tag = '0;
    logic [63:0] exp_form = '0;

    always #2.5 clk = ~clk;

    itx_fetch_xlate i_itx_fetch_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .cur_mode(cur_mode), .sp_en(sp_en), .ptbr(ptbr), .lookup_vpn(lookup_vpn),
        .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn), .tlb_rd_en(tlb_rd_en),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached),
        .rsp_fault(rsp_fault), .fault_tag(fault_tag), .fault_form(fault_form)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected result from the requirements, with the requirement that decides it.
    function automatic void model(input logic [63:0] va, input logic [1:0] m,
                                  input logic [1:0] sp, input logic hit,
                                  input logic [30:0] pfn, input logic [3:0] rde,
                                  output logic [1:0] f, output logic [43:0] pa,
                                  output logic unc, output string why);
        logic canon;
        canon = (va[63:42] == '0) || (va[63:42] == '1);
        f = 2'd0; pa = '0; unc = 1'b0;
        if (va[0]) begin
            pa = {va[43:2], 2'b00}; why = "R1";
        end else if (!canon) begin
            f = 2'd1; why = "R2";
        end else if (sp[1] && va[42:41] == 2'b10) begin
            if (m != 2'd0) begin
                f = 2'd1; why = "R4";
            end else begin
                pa = {4'b0, va[39:0]}; unc = pa[43]; why = "R3";
            end
        end else if (!hit) begin
            f = 2'd2; why = "R5";
        end else if (!rde[m]) begin
            f = 2'd1; why = "R7";
        end else begin
            pa = {pfn, va[12:2], 2'b00}; unc = pa[43]; why = "R6";
        end
    endfunction

    // Drive one request at the falling edge, check the response one clock later.
    task automatic run(input logic [63:0] va, input logic [1:0] m, input logic [1:0] sp,
                       input logic hit, input logic [30:0] pfn, input logic [3:0] rde,
                       input logic [63:0] base);
        logic [1:0]  f;
        logic [43:0] pa;
        logic        unc;
        string       why;
        req_valid = 1'b1; req_va = va; cur_mode = m; sp_en = sp;
        tlb_hit = hit; tlb_pfn = pfn; tlb_rd_en = rde; ptbr = base;
        model(va, m, sp, hit, pfn, rde, f, pa, unc, why);
        #1;
        check("R5 lookup_vpn", 64'(lookup_vpn), 64'(va[42:13]));
        if (f != 2'd0) begin
            exp_tag  = va;
            exp_form = base | (64'(va[42:13]) << 3);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check({why, " fault"}, 64'(rsp_fault), 64'(f));
        check({why, " pa"}, 64'(rsp_pa), 64'(pa));
        check({why, " R9 uncached"}, 64'(rsp_uncached), 64'(unc));
        check("R10 rsp_valid", 64'(rsp_valid), 64'd1);
        check("R8 fault_tag", fault_tag, exp_tag);
        check("R8 fault_form", fault_form, exp_form);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] va;
        logic        s;
        int          seed;
        seed = 12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        check("R10 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R10 reset rsp_pa", 64'(rsp_pa), 64'd0);
        check("R8 reset fault_tag", fault_tag, 64'd0);
        check("R8 reset fault_form", fault_form, 64'd0);

        // R1: bypass in user mode with a miss and bad range
        run(64'h8000_0123_4567_89AB, 2'd3, 2'b10, 1'b0, '0, 4'h0, 64'h1000);
        // R2: non-canonical
        run(64'h0001_0400_0000_2000, 2'd0, 2'b00, 1'b1, 31'h5, 4'hF, 64'hA000_0000);
        // R3: superpage, kernel, lookup says miss (ignored)
        run(64'hFFFF_FC80_1234_5678, 2'd0, 2'b10, 1'b0, '0, 4'h0, 64'h0);
        // R4: superpage, user mode
        run(64'hFFFF_FC80_1234_5678, 2'd3, 2'b10, 1'b1, 31'h7, 4'hF, 64'h2000_0000);
        // R5: superpage bit 0 only does not open the window -> miss
        run(64'hFFFF_FC80_1234_5678, 2'd0, 2'b01, 1'b0, '0, 4'hF, 64'h3000_0000);
        // R6 and R9: hit with top frame bit set -> uncached
        run(64'h0000_0000_0000_3FFE, 2'd2, 2'b00, 1'b1, 31'h4000_0001, 4'b0100, 64'h0);
        // R7: hit but the mode bit is clear
        run(64'h0000_0000_0004_0000, 2'd1, 2'b00, 1'b1, 31'h1, 4'b1101, 64'h4000_0000);
        // R8: idle cycle keeps fault registers
        @(negedge clk);
        check("R10 idle rsp_valid", 64'(rsp_valid), 64'd0);
        check("R8 hold tag", fault_tag, exp_tag);

        for (int n = 0; n < 3000; n++) begin
            case ($urandom % 8)
                0: va = {$urandom, $urandom} | 64'd1;
                1: begin
                    va = {{22{1'b0}}, $urandom, 10'($urandom)} & ~64'd1;
                    va[50 + ($urandom % 13)] = 1'b1;
                end
                2: va = {21'h1FFFFF, 2'b10, 9'($urandom), $urandom} & ~64'd1;
                default: begin
                    s  = 1'($urandom);
                    va = {{21{s}}, s, 10'($urandom), $urandom} & ~64'd1;
                end
            endcase
            run(va, 2'($urandom), 2'($urandom), ($urandom % 4) != 0,
                31'($urandom), 4'($urandom), {$urandom, $urandom});
            if (($urandom % 5) == 0) @(negedge clk);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule